// File: doc/BRIEF.md
# Raster Timing and Sync Generator

This block produces the beam position and the sync timing for a fixed raster of 312 lines per frame and 1024 clocks per line. A horizontal counter advances on every pixel clock and a vertical counter advances once per line. From these the block derives an active-low horizontal sync, an active-low composite vertical sync, a frame interrupt request, a flag for the visible pixel window and a one-clock end-of-line strobe. Downstream address and pixel logic uses these outputs.

The vertical sync does not close on a line boundary. It opens at the first clock of line 0 and closes halfway through line 2. The frame interrupt rises on the first line after the visible area and stays high until the frame wraps. Every output is a register loaded on the same clock edge as the counters, so the flags always match the `x` and `y` values that are on the port at that moment. All geometry values are parameters. The defaults give the 50 Hz-style raster.

Top module: `raster_timing_gen`

## Requirements
- R1: `x` advances by one on every clock from 0 to 1023 and then returns to 0. `y` advances by one each time `x` returns to 0.
- R2: `hsync_n` is 0 while `x` is 0 to 63 and 1 for every other value of `x`.
- R3: `csync_n` goes to 0 at `x`=0 of line 0, stays 0 through line 1, and goes back to 1 at `x`=512 of line 2. It stays 1 for the rest of the frame.
- R4: `active` is 1 exactly when `x` is in 256..895 and `y` is in 28..283. It is 0 everywhere else.
- R5: `irq_vsync` goes to 1 at `x`=0 of line 284 and stays 1 through line 311. It goes back to 0 at `x`=0 of line 0.
- R6: On the clock after `x`=1023 of line 311, both `x` and `y` become 0.
- R7: While `rst` is 1 at a rising clock edge, the outputs become `x`=0, `y`=0, `hsync_n`=0, `csync_n`=0, `irq_vsync`=0, `active`=0 and `eol`=0. This is the state of the first clock of a frame.
- R8: `eol` is 1 for exactly one clock, the clock where `x`=1023, and 0 on every other clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| x | output | XW (10) | Horizontal position within the line |
| y | output | YW (9) | Line number within the frame |
| hsync_n | output | 1 | Horizontal sync, active low |
| csync_n | output | 1 | Composite vertical sync, active low |
| irq_vsync | output | 1 | Frame interrupt request |
| active | output | 1 | High inside the visible pixel window |
| eol | output | 1 | One-clock strobe on the last clock of a line |

## Verification
Two events share a single clock edge. On the last clock of line 311, the horizontal wrap and the frame wrap happen together. The first clock of the next frame then lowers both syncs, clears the interrupt and resets both counters. The bench instantiates the block with a reduced geometry so that whole frames fit in the run. It steps across this boundary with a table of expected values and then with a cycle-by-cycle comparison against its own position model. It also checks the clock where the vertical sync closes mid-line against the clocks on either side of it.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

   typedef struct packed {
      logic hsync_n;
      logic csync_n;
      logic irq;
      logic active;
      logic eol;
   } rtg_flags_t;

   localparam rtg_flags_t RTG_FLAGS_RST = '{hsync_n: 1'b0, csync_n: 1'b0,
                                            irq: 1'b0, active: 1'b0, eol: 1'b0};

endpackage

// File: rtl/rtg_hcount.sv
module rtg_hcount #(
   parameter int LINE_CLKS = 1024,
   localparam int XW = $clog2(LINE_CLKS)
) (
   input  logic          clk,
   input  logic          rst,
   output logic [XW-1:0] x_q,
   output logic [XW-1:0] x_d,
   output logic          wrap
);
   localparam logic [XW-1:0] X_LAST = XW'(LINE_CLKS - 1);
   localparam bit POW2 = (LINE_CLKS == (1 << XW));

   assign wrap = (x_q == X_LAST);

   generate
      if (POW2) begin : g_natural_wrap
         assign x_d = x_q + 1'b1;
      end else begin : g_compare_wrap
         assign x_d = wrap ? '0 : x_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) x_q <= '0;
      else     x_q <= x_d;
   end
endmodule

// File: rtl/rtg_vcount.sv
module rtg_vcount #(
   parameter int FRAME_LINES = 312,
   localparam int YW = $clog2(FRAME_LINES)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          adv,
   output logic [YW-1:0] y_q,
   output logic [YW-1:0] y_d
);
   localparam logic [YW-1:0] Y_LAST = YW'(FRAME_LINES - 1);

   always_comb begin
      y_d = y_q;
      if (adv) y_d = (y_q == Y_LAST) ? '0 : y_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) y_q <= '0;
      else     y_q <= y_d;
   end
endmodule

// File: rtl/rtg_decode.sv
module rtg_decode
   import rtg_pkg::*;
#(
   parameter int LINE_CLKS   = 1024,
   parameter int FRAME_LINES = 312,
   parameter int HSYNC_END   = 64,
   parameter int VS_END_LINE = 2,
   parameter int VS_END_X    = 512,
   parameter int ACT_X0      = 256,
   parameter int ACT_W       = 640,
   parameter int ACT_Y0      = 28,
   parameter int ACT_H       = 256,
   localparam int XW = $clog2(LINE_CLKS),
   localparam int YW = $clog2(FRAME_LINES)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [XW-1:0] x_d,
   input  logic [YW-1:0] y_d,
   output rtg_flags_t    flags_q
);
   localparam logic [XW-1:0] HS_END  = XW'(HSYNC_END);
   localparam logic [XW-1:0] VX_END  = XW'(VS_END_X);
   localparam logic [XW-1:0] X_LAST  = XW'(LINE_CLKS - 1);
   localparam logic [XW-1:0] AX_LO   = XW'(ACT_X0);
   localparam logic [XW-1:0] AX_HI   = XW'(ACT_X0 + ACT_W - 1);
   localparam logic [YW-1:0] VL_END  = YW'(VS_END_LINE);
   localparam logic [YW-1:0] AY_LO   = YW'(ACT_Y0);
   localparam logic [YW-1:0] AY_HI   = YW'(ACT_Y0 + ACT_H - 1);
   localparam logic [YW-1:0] IRQ_LN  = YW'(ACT_Y0 + ACT_H);

   rtg_flags_t flags_d;

   // Flags are computed from the next position so they land with the counters.
   always_comb begin
      flags_d.hsync_n = (x_d >= HS_END);
      flags_d.csync_n = !((y_d < VL_END) || ((y_d == VL_END) && (x_d < VX_END)));
      flags_d.irq     = (y_d >= IRQ_LN);
      flags_d.active  = (x_d >= AX_LO) && (x_d <= AX_HI) &&
                        (y_d >= AY_LO) && (y_d <= AY_HI);
      flags_d.eol     = (x_d == X_LAST);
   end

   always_ff @(posedge clk) begin
      if (rst) flags_q <= RTG_FLAGS_RST;
      else     flags_q <= flags_d;
   end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
   import rtg_pkg::*;
#(
   parameter int LINE_CLKS   = 1024,
   parameter int FRAME_LINES = 312,
   parameter int HSYNC_END   = 64,
   parameter int VS_END_LINE = 2,
   parameter int VS_END_X    = 512,
   parameter int ACT_X0      = 256,
   parameter int ACT_W       = 640,
   parameter int ACT_Y0      = 28,
   parameter int ACT_H       = 256,
   localparam int XW = $clog2(LINE_CLKS),
   localparam int YW = $clog2(FRAME_LINES)
) (
   input  logic          clk,
   input  logic          rst,
   output logic [XW-1:0] x,
   output logic [YW-1:0] y,
   output logic          hsync_n,
   output logic          csync_n,
   output logic          irq_vsync,
   output logic          active,
   output logic          eol
);
   generate
      if (LINE_CLKS < 4) begin : g_bad_line
         $error("LINE_CLKS too small");
      end
      if (HSYNC_END < 1 || HSYNC_END >= LINE_CLKS) begin : g_bad_hs
         $error("HSYNC_END out of line");
      end
      if (VS_END_X >= LINE_CLKS || VS_END_LINE >= FRAME_LINES) begin : g_bad_vs
         $error("vsync end out of frame");
      end
      if (ACT_W < 1 || ACT_X0 + ACT_W > LINE_CLKS) begin : g_bad_ax
         $error("active window exceeds line");
      end
      if (ACT_H < 1 || ACT_Y0 + ACT_H >= FRAME_LINES) begin : g_bad_ay
         $error("active lines leave no interrupt line");
      end
   endgenerate

   logic [XW-1:0] x_d;
   logic [YW-1:0] y_d;
   logic          line_wrap;
   rtg_flags_t    flags;

   rtg_hcount #(.LINE_CLKS(LINE_CLKS)) u_hcount (
      .clk  (clk),
      .rst  (rst),
      .x_q  (x),
      .x_d  (x_d),
      .wrap (line_wrap)
   );

   rtg_vcount #(.FRAME_LINES(FRAME_LINES)) u_vcount (
      .clk (clk),
      .rst (rst),
      .adv (line_wrap),
      .y_q (y),
      .y_d (y_d)
   );

   rtg_decode #(
      .LINE_CLKS(LINE_CLKS), .FRAME_LINES(FRAME_LINES), .HSYNC_END(HSYNC_END),
      .VS_END_LINE(VS_END_LINE), .VS_END_X(VS_END_X), .ACT_X0(ACT_X0),
      .ACT_W(ACT_W), .ACT_Y0(ACT_Y0), .ACT_H(ACT_H)
   ) u_decode (
      .clk     (clk),
      .rst     (rst),
      .x_d     (x_d),
      .y_d     (y_d),
      .flags_q (flags)
   );

   assign hsync_n   = flags.hsync_n;
   assign csync_n   = flags.csync_n;
   assign irq_vsync = flags.irq;
   assign active    = flags.active;
   assign eol       = flags.eol;
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
   parameter int LINE_CLKS   = 1024,
   parameter int FRAME_LINES = 312,
   parameter int HSYNC_END   = 64,
   parameter int VS_END_LINE = 2,
   parameter int VS_END_X    = 512,
   parameter int ACT_X0      = 256,
   parameter int ACT_W       = 640,
   parameter int ACT_Y0      = 28,
   parameter int ACT_H       = 256,
   localparam int XW = $clog2(LINE_CLKS),
   localparam int YW = $clog2(FRAME_LINES)
) (
   input logic          clk,
   input logic          rst,
   input logic [XW-1:0] x,
   input logic [YW-1:0] y,
   input logic          hsync_n,
   input logic          csync_n,
   input logic          irq_vsync,
   input logic          active,
   input logic          eol
);
   localparam logic [XW-1:0] X_LAST = XW'(LINE_CLKS - 1);
   localparam logic [YW-1:0] Y_LAST = YW'(FRAME_LINES - 1);
   localparam logic [XW-1:0] HS_END = XW'(HSYNC_END);
   localparam logic [XW-1:0] VX_END = XW'(VS_END_X);
   localparam logic [YW-1:0] VL_END = YW'(VS_END_LINE);
   localparam logic [XW-1:0] AX_LO  = XW'(ACT_X0);
   localparam logic [XW-1:0] AX_HI  = XW'(ACT_X0 + ACT_W - 1);
   localparam logic [YW-1:0] AY_LO  = YW'(ACT_Y0);
   localparam logic [YW-1:0] AY_HI  = YW'(ACT_Y0 + ACT_H - 1);
   localparam logic [YW-1:0] IRQ_LN = YW'(ACT_Y0 + ACT_H);

   p_x_step_r1: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(x) != X_LAST) |-> x == $past(x) + 1'b1);
   p_y_step_r1: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(x) == X_LAST && $past(y) != Y_LAST) |-> y == $past(y) + 1'b1);
   p_hs_fall_r2: assert property (@(posedge clk) disable iff (rst)
      $fell(hsync_n) |-> x == '0);
   p_hs_rise_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(hsync_n) |-> x == HS_END);
   p_cs_rise_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(csync_n) |-> (y == VL_END && x == VX_END));
   p_cs_fall_r3: assert property (@(posedge clk) disable iff (rst)
      $fell(csync_n) |-> (y == '0 && x == '0));
   p_active_win_r4: assert property (@(posedge clk) disable iff (rst)
      active |-> (x >= AX_LO && x <= AX_HI && y >= AY_LO && y <= AY_HI));
   p_irq_rise_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_vsync) |-> (y == IRQ_LN && x == '0));
   p_irq_fall_r5: assert property (@(posedge clk) disable iff (rst)
      $fell(irq_vsync) |-> (y == '0 && x == '0));
   p_frame_wrap_r6: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(x) == X_LAST && $past(y) == Y_LAST) |-> (x == '0 && y == '0));
   p_reset_r7: assert property (@(posedge clk)
      $past(rst) |-> (x == '0 && y == '0 && !hsync_n && !csync_n && !irq_vsync && !active && !eol));
   p_eol_pos_r8: assert property (@(posedge clk) disable iff (rst)
      eol |-> x == X_LAST);
   p_eol_pulse_r8: assert property (@(posedge clk) disable iff (rst)
      eol |=> !eol);
endmodule

bind raster_timing_gen raster_timing_chk #(
   .LINE_CLKS(LINE_CLKS), .FRAME_LINES(FRAME_LINES), .HSYNC_END(HSYNC_END),
   .VS_END_LINE(VS_END_LINE), .VS_END_X(VS_END_X), .ACT_X0(ACT_X0),
   .ACT_W(ACT_W), .ACT_Y0(ACT_Y0), .ACT_H(ACT_H)
) u_chk (.*);

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;
   // Reduced geometry keeps whole frames inside the run time.
   localparam int L   = 128;
   localparam int F   = 39;
   localparam int HS  = 8;
   localparam int VL  = 2;
   localparam int VX  = 64;
   localparam int AX0 = 32;
   localparam int AW  = 80;
   localparam int AY0 = 4;
   localparam int AH  = 32;
   localparam int XW  = $clog2(L);
   localparam int YW  = $clog2(F);

   typedef struct packed {
      logic [7:0]  fr;
      logic [15:0] ln;
      logic [15:0] px;
      logic [4:0]  exp; // {hsync_n, csync_n, irq_vsync, active, eol}
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VECS [NV] = '{
      '{8'd0, 16'd0,   16'd0,   5'b00000},
      '{8'd0, 16'd0,   16'd7,   5'b00000},
      '{8'd0, 16'd0,   16'd8,   5'b10000},
      '{8'd0, 16'd0,   16'd127, 5'b10001},
      '{8'd0, 16'd1,   16'd0,   5'b00000},
      '{8'd0, 16'd2,   16'd63,  5'b10000},
      '{8'd0, 16'd2,   16'd64,  5'b11000},
      '{8'd0, 16'd3,   16'd0,   5'b01000},
      '{8'd0, 16'd3,   16'd32,  5'b11000},
      '{8'd0, 16'd4,   16'd31,  5'b11000},
      '{8'd0, 16'd4,   16'd32,  5'b11010},
      '{8'd0, 16'd4,   16'd111, 5'b11010},
      '{8'd0, 16'd4,   16'd112, 5'b11000},
      '{8'd0, 16'd35,  16'd111, 5'b11010},
      '{8'd0, 16'd35,  16'd127, 5'b11001},
      '{8'd0, 16'd36,  16'd0,   5'b01100},
      '{8'd0, 16'd36,  16'd40,  5'b11100},
      '{8'd0, 16'd38,  16'd127, 5'b11101},
      '{8'd1, 16'd0,   16'd0,   5'b00000}
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [XW-1:0] x;
   logic [YW-1:0] y;
   logic          hsync_n, csync_n, irq_vsync, active, eol;

   int total = 0;
   int bad   = 0;
   int n     = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   raster_timing_gen #(
      .LINE_CLKS(L), .FRAME_LINES(F), .HSYNC_END(HS), .VS_END_LINE(VL),
      .VS_END_X(VX), .ACT_X0(AX0), .ACT_W(AW), .ACT_Y0(AY0), .ACT_H(AH)
   ) u_dut (
      .clk(clk), .rst(rst), .x(x), .y(y), .hsync_n(hsync_n), .csync_n(csync_n),
      .irq_vsync(irq_vsync), .active(active), .eol(eol)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         if (bad < 25) $display("FAIL %s act=%0d exp=%0d at n=%0d", req, act, exp, n);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      n++;
   endtask

   function automatic logic [4:0] model(input int c);
      int mx, my;
      logic h, cs, q, a, e;
      mx = c % L;
      my = (c / L) % F;
      h  = (mx >= HS);
      cs = !((my < VL) || (my == VL && mx < VX));
      q  = (my >= AY0 + AH);
      a  = (mx >= AX0) && (mx < AX0 + AW) && (my >= AY0) && (my < AY0 + AH);
      e  = (mx == L - 1);
      return {h, cs, q, a, e};
   endfunction

   task automatic chk_flags(input logic [4:0] exp);
      chk("R2 hsync_n",   int'(hsync_n),   int'(exp[4]));
      chk("R3 csync_n",   int'(csync_n),   int'(exp[3]));
      chk("R5 irq_vsync", int'(irq_vsync), int'(exp[2]));
      chk("R4 active",    int'(active),    int'(exp[1]));
      chk("R8 eol",       int'(eol),       int'(exp[0]));
   endtask

   task automatic chk_reset_state();
      chk("R7 x",         int'(x),         0);
      chk("R7 y",         int'(y),         0);
      chk("R7 hsync_n",   int'(hsync_n),   0);
      chk("R7 csync_n",   int'(csync_n),   0);
      chk("R7 irq_vsync", int'(irq_vsync), 0);
      chk("R7 active",    int'(active),    0);
      chk("R7 eol",       int'(eol),       0);
   endtask

   initial begin : watchdog
      repeat (60000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk_reset_state();
      rst = 1'b0;
      n = 0;

      // Table walk, including the vsync end mid-line and the frame wrap (R6).
      for (int i = 0; i < NV; i++) begin
         int target;
         target = int'(VECS[i].fr) * L * F + int'(VECS[i].ln) * L + int'(VECS[i].px);
         while (n < target) step();
         chk("R1 x", int'(x), int'(VECS[i].px));
         chk(VECS[i].fr != 0 ? "R6 y" : "R1 y", int'(y), int'(VECS[i].ln));
         chk_flags(VECS[i].exp);
      end

      // Cycle-by-cycle sweep over the next full frame and a bit.
      for (int k = 0; k < L * F + 3 * L; k++) begin
         step();
         chk("R1 x", int'(x), n % L);
         chk("R1 y", int'(y), (n / L) % F);
         chk_flags(model(n));
      end

      // Reset in the middle of a frame.
      while ((n / L) % F != 37) step();
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk_reset_state();
      rst = 1'b0;
      n = 0;
      repeat (5) step();
      chk("R7 x after release", int'(x), 5);
      chk("R7 y after release", int'(y), 0);
      chk_flags(model(n));

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule